// File: doc/BRIEF.md
# Nested Exception Priority Arbiter

This block keeps the bookkeeping for a fixed set of exception sources and decides which pending source may begin handler entry. Each source can be raised by a one-cycle request pulse. Source 0 is the non-maskable source and source 1 is the hard-fault source. Both have fixed negative levels and cannot be switched off. Every other source carries a 3-bit configurable level and an enable bit, and a single global mask can silence all of them at once. A smaller level value means greater urgency.

The entry/exit sequencer sees `take_req` and `win_id`. When it starts entry it pulses `entry_ack`, and when the running handler finishes it pulses `handler_done`. The pair `take_req`/`entry_ack` works as a valid/ready handshake. `take_req` is the valid. The sequencer applies back-pressure simply by not acknowledging, and the offer then stays up for as long as its conditions hold. `win_id` may change while the offer waits: if a more urgent source becomes pending before the acknowledge, it replaces the earlier one (late arrival). An acknowledge takes whichever winner is shown in that same cycle.

Inside, the block holds a stack of the levels of the handlers that are running, so nested handlers unwind in order. The level on top of that stack is the current execution level, which is reported on `cur_prio`.

Top module: `exc_arbiter_top`

## Requirements
- R1: `pending_o[i]` and `active_o[i]` together encode the state of source i: inactive 0/0, pending 1/0, active 0/1, active-and-pending 1/1. A `req_set[i]` pulse sets `pending_o[i]` in the next cycle, whatever the current state.
- R2: Source 0 has level -2 and source 1 has level -1. Neither has an enable, and `mask_all` does not affect either. A pending source 0 wins whenever the current level is above -2 and the stack has room.
- R3: Source i (i >= 2) takes its level from `prio_cfg[(i-2)*3 +: 3]`, read as an unsigned value from 0 to 7. It is a candidate only while `src_en[i-2]` is 1 and `mask_all` is 0.
- R4: Among the candidates, the one with the smallest level wins. When levels are equal, the lower source number wins. `win_id` is meaningful only while `take_req` is 1.
- R5: `take_req` is 1 exactly when a candidate exists whose level is strictly below `cur_prio` and the stack is not full.
- R6: `preempt` is 1 exactly when `take_req` is 1 while at least one handler is active.
- R7: An `entry_ack` in a cycle with `take_req` set moves the winner from pending to active and pushes its level. `cur_prio` equals the top level, or 8 (the idle level) when the stack is empty.
- R8: `handler_done` pops the top entry and clears the active bit of that entry's source. On an empty stack it has no effect. When it coincides with `entry_ack`, the acknowledge is dropped.
- R9: An `entry_ack` in a cycle where `take_req` is 0 changes nothing.
- R10: While `rst_n` is low, every source is inactive, the stack is empty, `cur_prio` is 8 and `take_req` is 0.
- R11: When the stack holds 8 entries, `take_req` stays 0 even if source 0 or source 1 is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_set | input | NUM_SRC | One-cycle request pulse per source |
| src_en | input | NUM_SRC-2 | Enable for each configurable source (bit i-2 for source i) |
| prio_cfg | input | (NUM_SRC-2)*PRIO_W | Configurable levels, PRIO_W bits per source |
| mask_all | input | 1 | Global mask that blocks every configurable source |
| entry_ack | input | 1 | Sequencer begins entry of the offered winner |
| handler_done | input | 1 | The running handler has finished |
| take_req | output | 1 | An entry is offered |
| win_id | output | clog2(NUM_SRC) | Number of the offered source |
| preempt | output | 1 | The offered entry would interrupt a running handler |
| cur_prio | output | PRIO_W+2 (signed) | Current execution level |
| pending_o | output | NUM_SRC | Pending bit per source |
| active_o | output | NUM_SRC | Active bit per source |

## Verification
The bench targets several places where a faulty design would still look plausible. On a tie between equal levels, a wrong tie-break would offer the higher-numbered source. A wrong equal-level comparison would let a source preempt a handler of the same level. A wrong mask decode would block the non-maskable or hard-fault source, or would let a disabled source through. For the simultaneous acknowledge-and-finish cycle, a wrong ordering would push and pop in the same cycle and corrupt the stack. With the stack full, a missing full check would overflow it and a later return would restore the wrong level. It also repeats a request while that source is being serviced, to confirm that the active-and-pending state survives the handler's completion as a plain pending state.

// File: rtl/exc_arb_pkg.sv
`timescale 1ns/1ps
package exc_arb_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE     = 2'd0,
    SRC_PEND     = 2'd1,
    SRC_ACT      = 2'd2,
    SRC_ACT_PEND = 2'd3
  } src_state_e;

  localparam int NMI_ID    = 0;
  localparam int HFLT_ID   = 1;
  localparam int NMI_LVL   = -2;
  localparam int HFLT_LVL  = -1;
  localparam int FIXED_CNT = 2;
endpackage

// File: rtl/exc_src_state.sv
`timescale 1ns/1ps
module exc_src_state
  import exc_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic take,
  input  logic retire,
  output logic pend,
  output logic act
);
  src_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SRC_IDLE:     if (set_req) st_d = SRC_PEND;
      SRC_PEND:     if (take) st_d = set_req ? SRC_ACT_PEND : SRC_ACT;
      SRC_ACT: begin
        if (retire)       st_d = set_req ? SRC_PEND : SRC_IDLE;
        else if (set_req) st_d = SRC_ACT_PEND;
      end
      SRC_ACT_PEND: begin
        if (retire)    st_d = SRC_PEND;
        else if (take) st_d = set_req ? SRC_ACT_PEND : SRC_ACT;
      end
      default: st_d = SRC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SRC_IDLE;
    else        st_q <= st_d;
  end

  assign pend = (st_q == SRC_PEND) || (st_q == SRC_ACT_PEND);
  assign act  = (st_q == SRC_ACT)  || (st_q == SRC_ACT_PEND);
endmodule

// File: rtl/exc_winner_sel.sv
`timescale 1ns/1ps
module exc_winner_sel
  import exc_arb_pkg::*;
#(
  parameter int NUM_SRC = 10,
  parameter int PRIO_W  = 3,
  localparam int IDW    = $clog2(NUM_SRC),
  localparam int EW     = PRIO_W + 2,
  localparam int CFG_N  = NUM_SRC - FIXED_CNT
) (
  input  logic [NUM_SRC-1:0]      pend,
  input  logic [CFG_N-1:0]        en,
  input  logic [CFG_N*PRIO_W-1:0] prio_cfg,
  input  logic                    mask,
  output logic                    found,
  output logic [IDW-1:0]          win_id,
  output logic signed [EW-1:0]    win_lvl
);
  localparam logic signed [EW-1:0] IDLE_LVL = EW'(1 << PRIO_W);

  logic signed [EW-1:0] lvl [NUM_SRC];
  logic [NUM_SRC-1:0]   cand;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_lvl
    if (g == NMI_ID) begin : g_nmi
      assign lvl[g]  = EW'(NMI_LVL);
      assign cand[g] = pend[g];
    end else if (g == HFLT_ID) begin : g_hflt
      assign lvl[g]  = EW'(HFLT_LVL);
      assign cand[g] = pend[g];
    end else begin : g_cfg
      assign lvl[g]  = $signed({2'b00, prio_cfg[(g-FIXED_CNT)*PRIO_W +: PRIO_W]});
      assign cand[g] = pend[g] && en[g-FIXED_CNT] && !mask;
    end
  end

  // Strict compare keeps the lower-numbered source on equal levels.
  always_comb begin
    found   = 1'b0;
    win_id  = '0;
    win_lvl = IDLE_LVL;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i] && (!found || lvl[i] < win_lvl)) begin
        found   = 1'b1;
        win_id  = IDW'(i);
        win_lvl = lvl[i];
      end
    end
  end
endmodule

// File: rtl/exc_prio_stack.sv
`timescale 1ns/1ps
module exc_prio_stack #(
  parameter int DEPTH = 8,
  parameter int IDW   = 4,
  parameter int EW    = 5,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push,
  input  logic                 pop,
  input  logic [IDW-1:0]       push_id,
  input  logic signed [EW-1:0] push_lvl,
  output logic                 empty,
  output logic                 full,
  output logic [CW-1:0]        cnt,
  output logic [IDW-1:0]       top_id,
  output logic signed [EW-1:0] top_lvl
);
  logic [IDW-1:0]       id_q  [DEPTH];
  logic signed [EW-1:0] lvl_q [DEPTH];
  logic [CW-1:0]        cnt_q;
  logic [AW-1:0]        wr_idx, top_idx;

  assign wr_idx  = AW'(cnt_q);
  assign top_idx = AW'(cnt_q - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        id_q[i]  <= '0;
        lvl_q[i] <= '0;
      end
    end else if (push && !full) begin
      id_q[wr_idx]  <= push_id;
      lvl_q[wr_idx] <= push_lvl;
      cnt_q         <= cnt_q + CW'(1);
    end else if (pop && !empty) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign cnt     = cnt_q;
  assign top_id  = id_q[top_idx];
  assign top_lvl = lvl_q[top_idx];
endmodule

// File: rtl/exc_arbiter_top.sv
`timescale 1ns/1ps
module exc_arbiter_top
  import exc_arb_pkg::*;
#(
  parameter int NUM_SRC   = 10,
  parameter int PRIO_W    = 3,
  parameter int STK_DEPTH = 8,
  localparam int IDW      = $clog2(NUM_SRC),
  localparam int EW       = PRIO_W + 2,
  localparam int CFG_N    = NUM_SRC - FIXED_CNT,
  localparam int CW       = $clog2(STK_DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_SRC-1:0]      req_set,
  input  logic [CFG_N-1:0]        src_en,
  input  logic [CFG_N*PRIO_W-1:0] prio_cfg,
  input  logic                    mask_all,
  input  logic                    entry_ack,
  input  logic                    handler_done,
  output logic                    take_req,
  output logic [IDW-1:0]          win_id,
  output logic                    preempt,
  output logic signed [EW-1:0]    cur_prio,
  output logic [NUM_SRC-1:0]      pending_o,
  output logic [NUM_SRC-1:0]      active_o
);
  localparam logic signed [EW-1:0] IDLE_LVL = EW'(1 << PRIO_W);

  logic                 found;
  logic signed [EW-1:0] win_lvl;
  logic                 stk_empty, stk_full;
  logic [CW-1:0]        stk_cnt;
  logic [IDW-1:0]       top_id;
  logic signed [EW-1:0] top_lvl;
  logic                 do_push, do_pop;

  exc_winner_sel #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_sel (
    .pend     (pending_o),
    .en       (src_en),
    .prio_cfg (prio_cfg),
    .mask     (mask_all),
    .found    (found),
    .win_id   (win_id),
    .win_lvl  (win_lvl)
  );

  exc_prio_stack #(.DEPTH(STK_DEPTH), .IDW(IDW), .EW(EW)) u_stk (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (do_push),
    .pop      (do_pop),
    .push_id  (win_id),
    .push_lvl (win_lvl),
    .empty    (stk_empty),
    .full     (stk_full),
    .cnt      (stk_cnt),
    .top_id   (top_id),
    .top_lvl  (top_lvl)
  );

  assign cur_prio = stk_empty ? IDLE_LVL : top_lvl;
  assign take_req = found && (win_lvl < cur_prio) && !stk_full;
  assign preempt  = take_req && !stk_empty;
  assign do_pop   = handler_done && !stk_empty;
  assign do_push  = entry_ack && take_req && !handler_done;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    exc_src_state u_st (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_req (req_set[g]),
      .take    (do_push && (win_id == IDW'(g))),
      .retire  (do_pop && (top_id == IDW'(g))),
      .pend    (pending_o[g]),
      .act     (active_o[g])
    );
  end
endmodule

// File: rtl/exc_arbiter_chk.sv
`timescale 1ns/1ps
module exc_arbiter_chk #(
  parameter int NUM_SRC   = 10,
  parameter int PRIO_W    = 3,
  parameter int STK_DEPTH = 8,
  localparam int IDW      = $clog2(NUM_SRC),
  localparam int EW       = PRIO_W + 2,
  localparam int CW       = $clog2(STK_DEPTH + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_SRC-1:0]   req_set,
  input logic                 entry_ack,
  input logic                 handler_done,
  input logic                 take_req,
  input logic                 preempt,
  input logic [IDW-1:0]       win_id,
  input logic signed [EW-1:0] cur_prio,
  input logic [NUM_SRC-1:0]   pending_o,
  input logic [NUM_SRC-1:0]   active_o,
  input logic [CW-1:0]        stk_cnt,
  input logic                 stk_full
);
  assert_set_marks_pending_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_set != '0) |=> ((pending_o & $past(req_set)) == $past(req_set)));

  assert_nmi_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_o[0] && (cur_prio != EW'(-2)) && !stk_full) |-> (take_req && (win_id == '0)));

  assert_offer_is_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_req |-> pending_o[win_id]);

  assert_preempt_nested_R6: assert property (@(posedge clk) disable iff (!rst_n)
    preempt |-> (take_req && (stk_cnt != '0)));

  assert_ack_activates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_req && entry_ack && !handler_done) |=>
      (active_o[$past(win_id)] && (stk_cnt == $past(stk_cnt) + CW'(1))));

  assert_done_on_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (handler_done && (stk_cnt == '0)) |=> (active_o == $past(active_o)));

  assert_ack_unoffered_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_ack && !take_req && !handler_done) |=> (stk_cnt == $past(stk_cnt)));

  assert_full_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stk_full |-> !take_req);
endmodule

bind exc_arbiter_top exc_arbiter_chk #(
  .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .STK_DEPTH(STK_DEPTH)
) chk_i (.*);

// File: tb/exc_arbiter_top_tb_top.sv
`timescale 1ns/1ps
module exc_arbiter_top_tb_top;
  localparam int N   = 10;
  localparam int PW  = 3;
  localparam int D   = 8;
  localparam int CN  = N - 2;
  localparam int IDW = 4;
  localparam int EW  = 5;
  localparam int IDLE = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [N-1:0]     set_v  = '0;
  logic [CN-1:0]    en_v   = '0;
  logic [CN*PW-1:0] cfg_v  = '0;
  logic             mask_v = 1'b0;
  logic             ack_v  = 1'b0;
  logic             done_v = 1'b0;

  logic                 take_req, preempt;
  logic [IDW-1:0]       win_id;
  logic signed [EW-1:0] cur_prio;
  logic [N-1:0]         pending_o, active_o;

  exc_arbiter_top #(.NUM_SRC(N), .PRIO_W(PW), .STK_DEPTH(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_set(set_v), .src_en(en_v), .prio_cfg(cfg_v),
    .mask_all(mask_v), .entry_ack(ack_v), .handler_done(done_v),
    .take_req(take_req), .win_id(win_id), .preempt(preempt), .cur_prio(cur_prio),
    .pending_o(pending_o), .active_o(active_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit m_pend [N];
  bit m_act  [N];
  int stk_id [$];
  int stk_lvl[$];

  function automatic int lvl_of(int i);
    if (i == 0) return -2;
    if (i == 1) return -1;
    return int'(cfg_v[(i-2)*PW +: PW]);
  endfunction

  function automatic bit is_cand(int i);
    if (!m_pend[i]) return 1'b0;
    if (i < 2) return 1'b1;
    return en_v[i-2] && !mask_v;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < N; i++) begin
      m_pend[i] = 1'b0;
      m_act[i]  = 1'b0;
    end
    stk_id.delete();
    stk_lvl.delete();
  endtask

  // Called just after a falling edge with inputs applied.
  task automatic step(string ctx);
    int w, bl, cur, ep, ea, top;
    bit found, e_take, pop, push;
    #1;
    found = 1'b0; w = 0; bl = IDLE;
    for (int i = 0; i < N; i++)
      if (is_cand(i) && (!found || lvl_of(i) < bl)) begin
        found = 1'b1; w = i; bl = lvl_of(i);
      end
    cur = (stk_lvl.size() == 0) ? IDLE : stk_lvl[$];
    e_take = found && (bl < cur) && (stk_lvl.size() < D);
    ep = 0; ea = 0;
    for (int i = 0; i < N; i++) begin
      if (m_pend[i]) ep |= (1 << i);
      if (m_act[i])  ea |= (1 << i);
    end
    check({ctx, " R5 take_req"}, int'(take_req), int'(e_take));
    check({ctx, " R6 preempt"}, int'(preempt), int'(e_take && stk_lvl.size() > 0));
    check({ctx, " R7 cur_prio"}, int'(cur_prio), cur);
    check({ctx, " R1 pending"}, int'(pending_o), ep);
    check({ctx, " R1 active"}, int'(active_o), ea);
    if (e_take) check({ctx, " R4 win_id"}, int'(win_id), w);
    pop  = done_v && (stk_lvl.size() > 0);
    push = ack_v && e_take && !done_v;
    top  = pop ? stk_id[$] : -1;
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      if (pop && i == top) m_act[i] = 1'b0;
      if (push && i == w) begin m_pend[i] = 1'b0; m_act[i] = 1'b1; end
      if (set_v[i]) m_pend[i] = 1'b1;
    end
    if (pop) begin void'(stk_id.pop_back()); void'(stk_lvl.pop_back()); end
    if (push) begin stk_id.push_back(w); stk_lvl.push_back(bl); end
    @(negedge clk);
  endtask

  task automatic cyc(string ctx, logic [N-1:0] s, bit a, bit d);
    set_v = s; ack_v = a; done_v = d;
    step(ctx);
    set_v = '0; ack_v = 1'b0; done_v = 1'b0;
  endtask

  task automatic do_reset(string ctx);
    rst_n = 1'b0;
    #1;
    check({ctx, " R10 pending"}, int'(pending_o), 0);
    check({ctx, " R10 active"}, int'(active_o), 0);
    check({ctx, " R10 cur_prio"}, int'(cur_prio), IDLE);
    check({ctx, " R10 take_req"}, int'(take_req), 0);
    model_clear();
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic default_cfg();
    for (int k = 0; k < CN; k++) cfg_v[k*PW +: PW] = PW'(7 - k);
    en_v = '1;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    model_clear();
    default_cfg();
    @(negedge clk);
    do_reset("start");

    // R2/R3: mask blocks source 4 but not the fixed sources
    mask_v = 1'b1;
    cyc("R1 raise", 10'b00_0001_0001, 0, 0);
    cyc("R2 nmi through mask", '0, 1, 0);
    cyc("R2 hf below nmi", 10'b00_0000_0010, 0, 0);
    cyc("R2 hf waits", '0, 1, 0);
    cyc("R8 nmi done", '0, 0, 1);
    cyc("R2 hf enters", '0, 1, 0);
    cyc("R8 hf done", '0, 0, 1);
    cyc("R3 masked idle", '0, 1, 0);
    mask_v = 1'b0;
    cyc("R3 unmasked", '0, 1, 0);
    cyc("R8 done", '0, 0, 1);

    // R4 tie: sources 3 and 5 at level 2
    cfg_v[1*PW +: PW] = 3'd2;
    cfg_v[3*PW +: PW] = 3'd2;
    cyc("R4 raise tie", 10'b00_0010_1000, 0, 0);
    cyc("R4 tie lower id", '0, 1, 0);
    cyc("R5 equal no preempt", '0, 1, 0);
    cyc("R8 done tie", '0, 0, 1);
    cyc("R4 second", '0, 1, 0);
    cyc("R8 done second", '0, 0, 1);
    default_cfg();

    // R3 enable
    en_v[4] = 1'b0;
    cyc("R3 disabled raise", 10'b00_0100_0000, 0, 0);
    cyc("R3 disabled no take", '0, 1, 0);
    en_v[4] = 1'b1;
    cyc("R3 enabled", '0, 1, 0);
    cyc("R8 done en", '0, 0, 1);

    // R1 active-and-pending
    cyc("R1 raise 7", 10'b00_1000_0000, 0, 0);
    cyc("R1 enter 7", '0, 1, 0);
    cyc("R1 re-raise 7", 10'b00_1000_0000, 0, 0);
    cyc("R1 active-pending", '0, 0, 1);
    cyc("R1 back to pending", '0, 1, 0);
    cyc("R8 done 7", '0, 0, 1);

    // R9 ack with nothing offered
    cyc("R9 idle ack", '0, 1, 0);
    cyc("R9 after ack", '0, 0, 0);

    // R8 done and ack in the same cycle; R6 preempt
    cyc("R8 raise 2", 10'b00_0000_0100, 0, 0);
    cyc("R8 enter 2", '0, 1, 0);
    cyc("R6 raise 9", 10'b10_0000_0000, 0, 0);
    cyc("R8 ack+done", '0, 1, 1);
    cyc("R8 9 from idle", '0, 1, 0);
    cyc("R8 done 9", '0, 0, 1);
    cyc("R8 done empty", '0, 0, 1);

    // R11 stack fill
    for (int k = 0; k < CN; k++) begin
      cyc("R11 raise", N'(1 << (k + 2)), 0, 0);
      cyc("R11 nest", '0, 1, 0);
    end
    cyc("R11 raise hf", 10'b00_0000_0010, 0, 0);
    cyc("R11 full blocks", '0, 1, 0);
    cyc("R11 pop one", '0, 0, 1);
    cyc("R11 hf enters", '0, 1, 0);
    for (int k = 0; k < 10; k++) cyc("R8 drain", '0, 0, 1);

    // R10 reset mid-run
    cyc("R10 raise", 10'b01_0000_0101, 1, 0);
    cyc("R10 enter", '0, 1, 0);
    do_reset("mid");
    cyc("R10 after", '0, 0, 0);

    // random traffic
    for (int c = 0; c < 3000; c++) begin
      logic [N-1:0] s;
      if (c % 500 == 0) for (int k = 0; k < CN; k++) cfg_v[k*PW +: PW] = PW'($urandom_range(0, 7));
      if ($urandom_range(0, 99) < 3) mask_v = ~mask_v;
      if ($urandom_range(0, 99) < 2) en_v[$urandom_range(0, CN-1)] ^= 1'b1;
      s = '0;
      for (int i = 0; i < N; i++) if ($urandom_range(0, 99) < 5) s[i] = 1'b1;
      cyc("rand", s, $urandom_range(0, 99) < 60, $urandom_range(0, 99) < 25);
    end

    finish_run();
  end
endmodule